// File: doc/BRIEF.md
# Address-Window to Partition Lookup Table

This block resolves the partition number that owns an incoming memory-mapped I/O address. It holds a small table of address windows. Each window is described by a base and a mask, so its size is a power of two and its base is aligned to that size. A lookup presents an address. One clock later the block returns a hit flag, the partition number and the index of the entry that matched.

An entry runs in one of three modes:
- **Whole mode** gives the entire window to one programmed partition.
- **Full-split mode** cuts the window into as many equal slices as there are partitions. The top offset bits inside the window then name the partition directly.
- **Offset-split mode** cuts the window into 8, 64 or 128 slices. Slice n belongs to the programmed first partition plus n.

Software programs an entry with one operation and then turns it on with a second operation, in either split form or whole form. The block refuses any turn-on whose settings break the rules of the mode. It reports the refusal with a one-cycle error pulse.

Top module: `pe_window_map`

## Requirements
- R1: An address hits entry i when entry i is enabled and (address AND mask) equals base. A synchronous reset disables every entry.
- R2: In whole mode (mode code 0), a hit returns the partition number stored in the entry, whatever the offset inside the window.
- R3: In full-split mode (mode code 1), with a window of 2^W bytes, a hit returns address offset bits [W-1:W-8] as the partition number.
- R4: In offset-split mode (mode code 2), the slice-count code is 0 for 8 slices, 1 for 64 and 2 for 128. With S = log2(slice count), a hit returns (stored partition + offset bits [W-1:W-S]) modulo 256.
- R5: A whole-form turn-on (operation code 2) is accepted only for a whole-mode entry whose window is at least 32 MB, meaning mask bits [24:0] are zero. A refused turn-on raises cfg_err for one cycle and leaves the entry's enable state unchanged.
- R6: A split-form turn-on (operation code 1) is refused with cfg_err in any of these cases: the mode is not 1 or 2; a full-split window is smaller than 256 bytes; an offset-split entry has slice-count code 3; an offset-split entry has a stored partition that is not a multiple of its slice count; an offset-split window is smaller than its slice count.
- R7: Either turn-on is refused with cfg_err when the stored mask is not a run of ones above a run of zeros, or when the base has a bit set below the mask.
- R8: When several enabled entries hit, the lowest index wins.
- R9: With no hit, or with lk_valid low, lk_hit is 0 and lk_pe and lk_idx are 0.
- R10: Lookup results appear one clock after lk_valid. A configuration operation changes lookups that start on the next cycle, not on the same cycle. Programming (operation code 0) and disabling (operation code 3) both leave the entry disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_valid | input | 1 | Configuration operation strobe |
| cfg_op | input | 2 | 0 program, 1 split turn-on, 2 whole turn-on, 3 disable |
| cfg_idx | input | $clog2(N_ENT) | Target entry |
| cfg_base | input | ADDR_W | Window base (program) |
| cfg_mask | input | ADDR_W | Window mask (program) |
| cfg_mode | input | 2 | 0 whole, 1 full-split, 2 offset-split |
| cfg_pe | input | PE_W | Partition number or first partition |
| cfg_segc | input | 2 | Slice-count code for offset-split mode |
| cfg_err | output | 1 | Pulses one cycle after a refused turn-on |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | ADDR_W | Lookup address |
| lk_hit | output | 1 | Registered hit flag |
| lk_pe | output | PE_W | Registered partition number |
| lk_idx | output | $clog2(N_ENT) | Registered index of the winning entry |

## Verification
Faults in the block show up at the ports in distinct ways:
- A wrong enable bit appears on the first lookup after the operation. The result is a miss where a hit was due, or a hit on an entry that was just disabled.
- A wrongly latched mask, or a wrong window-size value, moves the slice boundaries. The partition then differs as soon as an offset near a boundary is looked up.
- A faulty rule check appears one cycle after the turn-on, either as a missing or extra cfg_err pulse or as an entry that hits when it should stay dark.
- A priority fault appears as the wrong lk_idx on overlapping windows.

A cycle-level model comparing every output on every clock catches each of these within one cycle of the first lookup that exposes it.

// File: rtl/pe_map_pkg.sv
package pe_map_pkg;

   typedef enum logic [1:0] {
      OP_PROG     = 2'd0,
      OP_EN_SPLIT = 2'd1,
      OP_EN_WHOLE = 2'd2,
      OP_DISABLE  = 2'd3
   } cfg_op_e;

   typedef enum logic [1:0] {
      MODE_WHOLE   = 2'd0,
      MODE_FULLSEG = 2'd1,
      MODE_BASESEG = 2'd2,
      MODE_RSVD    = 2'd3
   } win_mode_e;

   // log2 of the slice count for offset-split mode; 0 marks the illegal code
   function automatic int unsigned seg_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 3;
         2'd1:    return 6;
         2'd2:    return 7;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/pe_map_shape.sv
// Derives window size and shape legality from a base/mask pair at program time.
module pe_map_shape #(
   parameter int ADDR_W = 64,
   parameter int LOG_W  = $clog2(ADDR_W + 1)
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] mask,
   output logic [LOG_W-1:0]  wlog2,
   output logic              shape_ok
);
   logic [ADDR_W-1:0] inv;
   logic [ADDR_W-1:0] inv_inc;

   always_comb begin
      wlog2 = LOG_W'(ADDR_W);
      for (int k = ADDR_W - 1; k >= 0; k--) begin
         if (mask[k]) wlog2 = LOG_W'(k);
      end
   end

   assign inv      = ~mask;
   assign inv_inc  = inv + ADDR_W'(1);
   // contiguous ones above zeros, and no base bit inside the window
   assign shape_ok = ((inv & inv_inc) == '0) && ((base & inv) == '0);
endmodule

// File: rtl/pe_map_entry.sv
// One table entry: storage, turn-on rule checks and address match.
module pe_map_entry #(
   parameter int ADDR_W         = 64,
   parameter int PE_W           = 8,
   parameter int MIN_WHOLE_LOG2 = 25,
   parameter int LOG_W          = $clog2(ADDR_W + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [1:0]        op,
   input  logic [ADDR_W-1:0] in_base,
   input  logic [ADDR_W-1:0] in_mask,
   input  logic [1:0]        in_mode,
   input  logic [PE_W-1:0]   in_pe,
   input  logic [1:0]        in_segc,
   input  logic [LOG_W-1:0]  in_wlog2,
   input  logic              in_shape_ok,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              match,
   output logic [ADDR_W-1:0] o_mask,
   output logic [1:0]        o_mode,
   output logic [PE_W-1:0]   o_pe,
   output logic [1:0]        o_segc,
   output logic [LOG_W-1:0]  o_wlog2,
   output logic              o_reject
);
   import pe_map_pkg::*;

   logic [ADDR_W-1:0] base_q, mask_q;
   logic [1:0]        mode_q, segc_q;
   logic [PE_W-1:0]   pe_q;
   logic [LOG_W-1:0]  wlog2_q;
   logic              shape_q, en_q;

   logic [LOG_W-1:0]  sb;
   logic [PE_W-1:0]   pe_low_mask;
   logic              whole_ok, split_ok;
   cfg_op_e           op_e;

   assign op_e        = cfg_op_e'(op);
   assign sb          = LOG_W'(seg_bits(segc_q));
   assign pe_low_mask = PE_W'((32'd1 << sb) - 32'd1);

   always_comb begin
      whole_ok = (win_mode_e'(mode_q) == MODE_WHOLE) && (wlog2_q >= LOG_W'(MIN_WHOLE_LOG2));
      case (win_mode_e'(mode_q))
         MODE_FULLSEG: split_ok = (wlog2_q >= LOG_W'(PE_W));
         MODE_BASESEG: split_ok = (segc_q != 2'd3) && (wlog2_q >= sb) &&
                                  ((pe_q & pe_low_mask) == '0);
         default:      split_ok = 1'b0;
      endcase
      case (op_e)
         OP_EN_SPLIT: o_reject = !shape_q || !split_ok;
         OP_EN_WHOLE: o_reject = !shape_q || !whole_ok;
         default:     o_reject = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q    <= 1'b0;
         base_q  <= '0;
         mask_q  <= '0;
         mode_q  <= '0;
         pe_q    <= '0;
         segc_q  <= '0;
         wlog2_q <= '0;
         shape_q <= 1'b0;
      end else if (wr_en) begin
         case (op_e)
            OP_PROG: begin
               en_q    <= 1'b0;
               base_q  <= in_base;
               mask_q  <= in_mask;
               mode_q  <= in_mode;
               pe_q    <= in_pe;
               segc_q  <= in_segc;
               wlog2_q <= in_wlog2;
               shape_q <= in_shape_ok;
            end
            OP_EN_SPLIT, OP_EN_WHOLE: begin
               if (!o_reject) en_q <= 1'b1;
            end
            default: en_q <= 1'b0;
         endcase
      end
   end

   assign match   = en_q && ((lk_addr & mask_q) == base_q);
   assign o_mask  = mask_q;
   assign o_mode  = mode_q;
   assign o_pe    = pe_q;
   assign o_segc  = segc_q;
   assign o_wlog2 = wlog2_q;
endmodule

// File: rtl/pe_map_prio.sv
// Lowest-index-wins selection over the match vector.
module pe_map_prio #(
   parameter int N     = 16,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req[k]) idx = IDX_W'(k);
      end
   end
   assign any = |req;
endmodule

// File: rtl/pe_map_pecalc.sv
// Turns the offset inside the winning window into a partition number.
module pe_map_pecalc #(
   parameter int ADDR_W = 64,
   parameter int PE_W   = 8,
   parameter int LOG_W  = $clog2(ADDR_W + 1)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] mask,
   input  logic [1:0]        mode,
   input  logic [PE_W-1:0]   pe,
   input  logic [1:0]        segc,
   input  logic [LOG_W-1:0]  wlog2,
   output logic [PE_W-1:0]   pe_out
);
   import pe_map_pkg::*;

   logic [ADDR_W-1:0] offset, slice, slice_mask;
   logic [LOG_W-1:0]  sb, sh;

   always_comb begin
      sb         = (win_mode_e'(mode) == MODE_FULLSEG) ? LOG_W'(PE_W) : LOG_W'(seg_bits(segc));
      sh         = (wlog2 >= sb) ? (wlog2 - sb) : '0;
      offset     = addr & ~mask;
      slice_mask = {ADDR_W{1'b1}} >> (LOG_W'(ADDR_W) - sb);
      slice      = (offset >> sh) & slice_mask;
      case (win_mode_e'(mode))
         MODE_FULLSEG: pe_out = slice[PE_W-1:0];
         MODE_BASESEG: pe_out = pe + slice[PE_W-1:0];
         default:      pe_out = pe;
      endcase
   end
endmodule

// File: rtl/pe_window_map.sv
module pe_window_map #(
   parameter int ADDR_W         = 64,
   parameter int N_ENT          = 16,
   parameter int PE_W           = 8,
   parameter int MIN_WHOLE_LOG2 = 25
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     cfg_valid,
   input  logic [1:0]               cfg_op,
   input  logic [$clog2(N_ENT)-1:0] cfg_idx,
   input  logic [ADDR_W-1:0]        cfg_base,
   input  logic [ADDR_W-1:0]        cfg_mask,
   input  logic [1:0]               cfg_mode,
   input  logic [PE_W-1:0]          cfg_pe,
   input  logic [1:0]               cfg_segc,
   output logic                     cfg_err,
   input  logic                     lk_valid,
   input  logic [ADDR_W-1:0]        lk_addr,
   output logic                     lk_hit,
   output logic [PE_W-1:0]          lk_pe,
   output logic [$clog2(N_ENT)-1:0] lk_idx
);
   import pe_map_pkg::*;

   localparam int IDX_W = $clog2(N_ENT);
   localparam int LOG_W = $clog2(ADDR_W + 1);

   if (PE_W < 7 || PE_W > 16) begin : g_bad_pe_w
      $error("PE_W must lie in 7..16");
   end
   if (N_ENT < 2) begin : g_bad_n_ent
      $error("N_ENT must be at least 2");
   end
   if (MIN_WHOLE_LOG2 >= ADDR_W || ADDR_W <= PE_W) begin : g_bad_addr_w
      $error("ADDR_W too small for the window rules");
   end

   logic [LOG_W-1:0]  new_wlog2;
   logic              new_shape_ok;

   logic [N_ENT-1:0]  e_match, e_reject;
   logic [ADDR_W-1:0] e_mask  [N_ENT];
   logic [1:0]        e_mode  [N_ENT];
   logic [PE_W-1:0]   e_pe    [N_ENT];
   logic [1:0]        e_segc  [N_ENT];
   logic [LOG_W-1:0]  e_wlog2 [N_ENT];

   logic              win_any;
   logic [IDX_W-1:0]  win_idx;
   logic [PE_W-1:0]   win_pe;
   logic              is_enable_op;

   pe_map_shape #(.ADDR_W(ADDR_W), .LOG_W(LOG_W)) i_shape (
      .base     (cfg_base),
      .mask     (cfg_mask),
      .wlog2    (new_wlog2),
      .shape_ok (new_shape_ok)
   );

   for (genvar g = 0; g < N_ENT; g++) begin : g_ent
      pe_map_entry #(
         .ADDR_W(ADDR_W), .PE_W(PE_W), .MIN_WHOLE_LOG2(MIN_WHOLE_LOG2), .LOG_W(LOG_W)
      ) i_ent (
         .clk         (clk),
         .rst         (rst),
         .wr_en       (cfg_valid && (cfg_idx == IDX_W'(g))),
         .op          (cfg_op),
         .in_base     (cfg_base),
         .in_mask     (cfg_mask),
         .in_mode     (cfg_mode),
         .in_pe       (cfg_pe),
         .in_segc     (cfg_segc),
         .in_wlog2    (new_wlog2),
         .in_shape_ok (new_shape_ok),
         .lk_addr     (lk_addr),
         .match       (e_match[g]),
         .o_mask      (e_mask[g]),
         .o_mode      (e_mode[g]),
         .o_pe        (e_pe[g]),
         .o_segc      (e_segc[g]),
         .o_wlog2     (e_wlog2[g]),
         .o_reject    (e_reject[g])
      );
   end

   pe_map_prio #(.N(N_ENT), .IDX_W(IDX_W)) i_prio (
      .req (e_match),
      .any (win_any),
      .idx (win_idx)
   );

   pe_map_pecalc #(.ADDR_W(ADDR_W), .PE_W(PE_W), .LOG_W(LOG_W)) i_calc (
      .addr   (lk_addr),
      .mask   (e_mask[win_idx]),
      .mode   (e_mode[win_idx]),
      .pe     (e_pe[win_idx]),
      .segc   (e_segc[win_idx]),
      .wlog2  (e_wlog2[win_idx]),
      .pe_out (win_pe)
   );

   assign is_enable_op = (cfg_op_e'(cfg_op) == OP_EN_SPLIT) || (cfg_op_e'(cfg_op) == OP_EN_WHOLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_err <= 1'b0;
         lk_hit  <= 1'b0;
         lk_pe   <= '0;
         lk_idx  <= '0;
      end else begin
         cfg_err <= cfg_valid && is_enable_op && e_reject[cfg_idx];
         lk_hit  <= lk_valid && win_any;
         lk_pe   <= (lk_valid && win_any) ? win_pe  : '0;
         lk_idx  <= (lk_valid && win_any) ? win_idx : '0;
      end
   end
endmodule

// File: rtl/pe_window_map_chk.sv
module pe_window_map_chk #(
   parameter int ADDR_W = 64,
   parameter int N_ENT  = 16,
   parameter int PE_W   = 8
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     cfg_valid,
   input logic [1:0]               cfg_op,
   input logic [$clog2(N_ENT)-1:0] cfg_idx,
   input logic                     cfg_err,
   input logic                     lk_valid,
   input logic                     lk_hit,
   input logic [PE_W-1:0]          lk_pe,
   input logic [$clog2(N_ENT)-1:0] lk_idx
);
   // R9: a miss drives zeros
   a_r9_miss_zero: assert property (@(posedge clk) disable iff (rst)
      !lk_hit |-> (lk_pe == '0 && lk_idx == '0));

   // R9: a hit only answers a lookup strobe of the previous cycle
   a_r9_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
      lk_hit |-> $past(lk_valid));

   // R5: error pulses only follow a turn-on request
   a_r5_err_after_enable: assert property (@(posedge clk) disable iff (rst)
      cfg_err |-> $past(cfg_valid && (cfg_op == 2'd1 || cfg_op == 2'd2)));

   // R6: programming never raises an error
   a_r6_prog_no_err: assert property (@(posedge clk) disable iff (rst)
      (cfg_valid && cfg_op == 2'd0) |=> !cfg_err);

   // R10: an entry that was programmed or disabled answers no lookup of the next cycle
   a_r10_off_next_cycle: assert property (@(posedge clk) disable iff (rst)
      (cfg_valid && (cfg_op == 2'd0 || cfg_op == 2'd3)) ##1 lk_valid
      |=> !(lk_hit && lk_idx == $past(cfg_idx, 2)));
endmodule

bind pe_window_map pe_window_map_chk #(.ADDR_W(ADDR_W), .N_ENT(N_ENT), .PE_W(PE_W)) i_chk (.*);

// File: tb/test_pe_window_map.sv
`timescale 1ns/1ps
module test_pe_window_map;
   localparam int NE = 16;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_valid = 1'b0;
   logic [1:0]  cfg_op = '0;
   logic [3:0]  cfg_idx = '0;
   logic [63:0] cfg_base = '0, cfg_mask = '0;
   logic [1:0]  cfg_mode = '0;
   logic [7:0]  cfg_pe = '0;
   logic [1:0]  cfg_segc = '0;
   logic        cfg_err;
   logic        lk_valid = 1'b0;
   logic [63:0] lk_addr = '0;
   logic        lk_hit;
   logic [7:0]  lk_pe;
   logic [3:0]  lk_idx;

   always #4 clk = ~clk;

   pe_window_map i_pe_window_map (
      .clk, .rst, .cfg_valid, .cfg_op, .cfg_idx, .cfg_base, .cfg_mask, .cfg_mode,
      .cfg_pe, .cfg_segc, .cfg_err, .lk_valid, .lk_addr, .lk_hit, .lk_pe, .lk_idx
   );

   int    n_chk = 0, n_fail = 0;
   string tag = "R1";
   bit    armed = 1'b0;

   task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit          m_en   [NE];
   logic [63:0] m_base [NE];
   logic [63:0] m_mask [NE];
   int          m_mode [NE], m_pe [NE], m_segc [NE];
   bit          e_hit, e_err;
   int          e_pe, e_idx;

   function automatic int win_log2(logic [63:0] m);
      int k = 0;
      while (k < 64 && !m[k]) k++;
      return k;
   endfunction

   function automatic bit shape_good(logic [63:0] b, logic [63:0] m);
      bit seen = 0;
      for (int k = 0; k < 64; k++) begin
         if (m[k]) seen = 1;
         else if (seen) return 0;
      end
      return (b & ~m) == 0;
   endfunction

   function automatic int slice_count(int code);
      return (code == 0) ? 8 : (code == 1) ? 64 : (code == 2) ? 128 : 0;
   endfunction

   function automatic bit turn_on_ok(int i, int op);
      int w = win_log2(m_mask[i]);
      int cnt = slice_count(m_segc[i]);
      if (!shape_good(m_base[i], m_mask[i])) return 0;
      if (op == 2) return (m_mode[i] == 0) && (w >= 25);
      if (m_mode[i] == 1) return w >= 8;
      if (m_mode[i] == 2) return (cnt != 0) && ((1 << w) >= cnt || w >= 31) && (m_pe[i] % cnt == 0);
      return 0;
   endfunction

   function automatic int expect_pe(int i, logic [63:0] a);
      logic [63:0] off = a & ~m_mask[i];
      int w = win_log2(m_mask[i]);
      int cnt = slice_count(m_segc[i]);
      if (m_mode[i] == 1) return int'((off >> (w - 8)) % 256);
      if (m_mode[i] == 2) return int'((m_pe[i] + (off / (64'd1 << w) * 0) + (off >> (w - $clog2(cnt)))) % 256);
      return m_pe[i];
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NE; i++) m_en[i] = 0;
         e_hit = 0; e_pe = 0; e_idx = 0; e_err = 0;
      end else begin
         e_hit = 0; e_pe = 0; e_idx = 0;
         if (lk_valid)
            for (int i = NE - 1; i >= 0; i--)
               if (m_en[i] && ((lk_addr & m_mask[i]) == m_base[i])) begin
                  e_hit = 1; e_idx = i; e_pe = expect_pe(i, lk_addr);
               end
         e_err = 0;
         if (cfg_valid) begin
            case (cfg_op)
               2'd0: begin
                  m_en[cfg_idx] = 0;   m_base[cfg_idx] = cfg_base; m_mask[cfg_idx] = cfg_mask;
                  m_mode[cfg_idx] = cfg_mode; m_pe[cfg_idx] = cfg_pe; m_segc[cfg_idx] = cfg_segc;
               end
               2'd1, 2'd2: begin
                  if (turn_on_ok(cfg_idx, cfg_op)) m_en[cfg_idx] = 1;
                  else e_err = 1;
               end
               default: m_en[cfg_idx] = 0;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (armed && !rst) begin
         chk(tag, "model lk_hit", lk_hit, e_hit);
         chk(tag, "model lk_pe", lk_pe, e_pe);
         chk(tag, "model lk_idx", lk_idx, e_idx);
         chk(tag, "model cfg_err", cfg_err, e_err);
      end
   end

   // ---------------- stimulus helpers (called just after a falling edge) ----------------
   task automatic prog(int idx, logic [63:0] b, logic [63:0] m, int mode, int pe, int segc);
      cfg_valid = 1; cfg_op = 2'd0; cfg_idx = 4'(idx);
      cfg_base = b; cfg_mask = m; cfg_mode = 2'(mode); cfg_pe = 8'(pe); cfg_segc = 2'(segc);
      @(negedge clk);
      cfg_valid = 0;
   endtask

   task automatic cfg_cmd(string req, int idx, int op, bit exp_err);
      cfg_valid = 1; cfg_op = 2'(op); cfg_idx = 4'(idx);
      @(negedge clk);
      cfg_valid = 0;
      chk(req, "cfg_err", cfg_err, exp_err);
   endtask

   task automatic look(string req, logic [63:0] a, bit hit, int pe, int idx);
      lk_valid = 1; lk_addr = a;
      @(negedge clk);
      lk_valid = 0;
      chk(req, "lk_hit", lk_hit, hit);
      chk(req, "lk_pe", lk_pe, pe);
      chk(req, "lk_idx", lk_idx, idx);
   endtask

   localparam logic [63:0] M32M = 64'hFFFF_FFFF_FE00_0000;
   localparam logic [63:0] M1M  = 64'hFFFF_FFFF_FFF0_0000;

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      armed = 1;
      tag = "R1";
      chk("R1", "reset lk_hit", lk_hit, 0);
      chk("R1", "reset cfg_err", cfg_err, 0);

      // R2 whole mode
      tag = "R2";
      prog(0, 64'h1_0000_0000, M32M, 0, 'h2A, 0);
      cfg_cmd("R2", 0, 2, 0);
      look("R2", 64'h1_0123_4567, 1, 'h2A, 0);
      look("R2", 64'h1_01FF_FFF0, 1, 'h2A, 0);
      look("R9", 64'h2_0000_0000, 0, 0, 0);

      // R5 window too small for whole
      tag = "R5";
      prog(1, 64'h2_0000_0000, 64'hFFFF_FFFF_FF00_0000, 0, 'h05, 0);
      cfg_cmd("R5", 1, 2, 1);
      look("R5", 64'h2_0000_0010, 0, 0, 0);

      // R3 full-split
      tag = "R3";
      prog(2, 64'h40_0000_0000, 64'hFFFF_FFFF_0000_0000, 1, 0, 0);
      cfg_cmd("R3", 2, 1, 0);
      look("R3", 64'h40_3700_1234, 1, 'h37, 2);
      cfg_cmd("R5", 2, 2, 1);
      look("R5", 64'h40_FF00_0000, 1, 'hFF, 2);

      // R4 offset-split, all three slice counts
      tag = "R4";
      prog(3, 64'h80_0000_0000, M1M, 2, 'h40, 1);
      cfg_cmd("R4", 3, 1, 0);
      look("R4", 64'h80_0000_C000, 1, 'h43, 3);
      prog(4, 64'h90_0000_0000, M1M, 2, 'h80, 2);
      cfg_cmd("R4", 4, 1, 0);
      look("R4", 64'h90_000F_E000, 1, 'hFF, 4);
      prog(5, 64'hA0_0000_0000, M1M, 2, 'h18, 0);
      cfg_cmd("R4", 5, 1, 0);
      look("R4", 64'hA0_000E_0000, 1, 'h1F, 5);

      // R6 split rules
      tag = "R6";
      prog(6, 64'hB0_0000_0000, M1M, 2, 'h20, 1);
      cfg_cmd("R6", 6, 1, 1);
      prog(6, 64'hB0_0000_0000, M1M, 2, 0, 3);
      cfg_cmd("R6", 6, 1, 1);
      prog(6, 64'hB0_0000_0000, M32M, 0, 'h09, 0);
      cfg_cmd("R6", 6, 1, 1);
      prog(6, 64'hB0_0000_0000, 64'hFFFF_FFFF_FFFF_FF80, 1, 0, 0);
      cfg_cmd("R6", 6, 1, 1);
      look("R6", 64'hB0_0000_0000, 0, 0, 0);

      // R7 shape rules
      tag = "R7";
      prog(7, 64'hC0_0000_0000, 64'hFFFF_FFFF_FF0F_0000, 1, 0, 0);
      cfg_cmd("R7", 7, 1, 1);
      prog(7, 64'hC0_0000_1000, 64'hFFFF_FFFF_0000_0000, 1, 0, 0);
      cfg_cmd("R7", 7, 1, 1);
      look("R7", 64'hC0_0000_1000, 0, 0, 0);

      // R8 priority
      tag = "R8";
      prog(8, 64'hD0_0000_0000, M32M, 0, 'h11, 0);
      cfg_cmd("R8", 8, 2, 0);
      prog(9, 64'hD0_0000_0000, 64'hFFFF_FFFF_FC00_0000, 0, 'h22, 0);
      cfg_cmd("R8", 9, 2, 0);
      look("R8", 64'hD0_0000_0100, 1, 'h11, 8);
      look("R8", 64'hD0_0200_0000, 1, 'h22, 9);
      cfg_cmd("R10", 8, 3, 0);
      look("R8", 64'hD0_0000_0100, 1, 'h22, 9);

      // R10 same-cycle config does not affect the lookup
      tag = "R10";
      cfg_valid = 1; cfg_op = 2'd3; cfg_idx = 4'd9;
      lk_valid = 1; lk_addr = 64'hD0_0000_0100;
      @(negedge clk);
      cfg_valid = 0; lk_valid = 0;
      chk("R10", "same-cycle lk_hit", lk_hit, 1);
      chk("R10", "same-cycle lk_idx", lk_idx, 9);
      look("R10", 64'hD0_0000_0100, 0, 0, 0);
      prog(0, 64'h1_0000_0000, M32M, 0, 'h2A, 0);
      look("R10", 64'h1_0123_4567, 0, 0, 0);
      cfg_cmd("R10", 0, 2, 0);
      look("R10", 64'h1_0123_4567, 1, 'h2A, 0);

      // R9 strobe low
      tag = "R9";
      lk_valid = 0; lk_addr = 64'h1_0123_4567;
      @(negedge clk);
      chk("R9", "idle lk_hit", lk_hit, 0);
      chk("R9", "idle lk_pe", lk_pe, 0);

      // R1 random lookups against the model
      tag = "R1";
      for (int n = 0; n < 400; n++) begin
         logic [63:0] bases [6];
         bases = '{64'h1_0000_0000, 64'h40_0000_0000, 64'h80_0000_0000,
                   64'h90_0000_0000, 64'hA0_0000_0000, 64'hD0_0000_0000};
         lk_valid = ($urandom % 4) != 0;
         lk_addr  = bases[$urandom % 6] | 64'($urandom % 32'h0400_0000);
         @(negedge clk);
      end
      lk_valid = 0;

      // R1 reset disables everything
      rst = 1;
      repeat (2) @(negedge clk);
      rst = 0;
      look("R1", 64'h40_3700_1234, 0, 0, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule